// File: doc/BRIEF.md
# Packed SIMD Integer Multiply Unit

This unit runs the single-width integer multiply group of a vector extension over one 64-bit slice of packed elements. It takes a 32-bit instruction word and decodes the operation and the operand form from it. It also takes two packed vector operands, a scalar operand, an element mask and the previous destination slice. A two-bit width select splits the slice into eight 8-bit, four 16-bit, two 32-bit or one 64-bit element.

For every element the unit forms the full double-width product. It then keeps either the low half or the high half. The high half can come from a signed by signed, an unsigned by unsigned, or a signed by unsigned product. The result is registered and appears with a valid flag one clock after the request. A word that is not a supported multiply sets an illegal flag instead of a valid result.

Top module: `simd_mul_unit`

## Requirements
- R1: A request is legal only when bits [6:0] equal 1010111, bits [14:12] equal 010 or 110, and bits [31:26] equal 100101, 100111, 100100 or 100110. Any other word with `in_valid` high sets `illegal` to 1 and `out_valid` to 0 on the next cycle.
- R2: A legal request with `in_valid` high sets `out_valid` to 1 on the next cycle, with the result on `out_data`. A cycle with `in_valid` low gives `out_valid` 0 and `illegal` 0 on the next cycle. The two flags are never both 1.
- R3: Bits [31:26] = 100101 return the low SEW bits of each product. This value is the same whether the operands are read as signed or unsigned.
- R4: Bits [31:26] = 100111 return bits [2·SEW−1:SEW] of the product of the two elements, both read as signed.
- R5: Bits [31:26] = 100100 return the upper SEW bits of the product, both operands read as unsigned.
- R6: Bits [31:26] = 100110 return the upper SEW bits of the product. The `vs2` element is read as signed and the `vs1` element or the scalar as unsigned. This holds at 64 bits too, where the full product spans 128 bits.
- R7: `sew` 00, 01, 10 and 11 select element widths of 8, 16, 32 and 64 bits. Element i occupies bits [i·SEW+SEW−1 : i·SEW] of every packed operand and of the result.
- R8: Bits [14:12] = 010 take one `vs1` element per lane. Bits [14:12] = 110 take the low SEW bits of `scalar` for every lane, and the upper scalar bits have no effect.
- R9: When bit 25 is 0 and `mask[i]` is 0, element i of the result equals element i of `old_dst`. When bit 25 is 1, every element is computed whatever the mask holds.
- R10: Reset clears `out_valid`, `illegal` and `out_data` to 0. `out_data` keeps its value in any cycle that accepts no legal request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present this cycle |
| instr | input | 32 | Instruction word |
| sew | input | 2 | Element width select (8/16/32/64) |
| vs2 | input | 64 | Packed first vector operand (the signed side in mixed mode) |
| vs1 | input | 64 | Packed second vector operand |
| scalar | input | 64 | Scalar operand for the vector-scalar form |
| mask | input | 8 | Per-element mask, bit i for element i |
| old_dst | input | 64 | Previous destination slice, kept in masked-off lanes |
| out_valid | output | 1 | Result valid, one cycle after a legal request |
| out_data | output | 64 | Packed result |
| illegal | output | 1 | Previous request was not a supported multiply |

## Verification
Every result, and the `illegal` and `out_valid` flags, is due exactly one clock after the cycle in which the request is presented. There is a single register stage between the inputs and the outputs. The bench drives each request on a falling edge and holds it through the following rising edge. It then samples the outputs on the next falling edge, so each check reads the registered value that this one request produced. `in_valid` is then dropped for a cycle. This lets the hold behaviour and the clearing of both flags be observed before the next request is applied.

// File: rtl/simd_mul_pkg.sv
package simd_mul_pkg;

    localparam int unsigned SLICE_W = 64;
    localparam int unsigned MAX_LANES = 8;

    localparam logic [6:0] MAJOR_OP  = 7'b1010111;
    localparam logic [2:0] FORM_VV   = 3'b010;
    localparam logic [2:0] FORM_VX   = 3'b110;
    localparam logic [5:0] SEL_LOW   = 6'b100101;
    localparam logic [5:0] SEL_HI_SS = 6'b100111;
    localparam logic [5:0] SEL_HI_UU = 6'b100100;
    localparam logic [5:0] SEL_HI_SU = 6'b100110;

    typedef enum logic [1:0] {
        MUL_LOW   = 2'd0,
        MUL_HI_SS = 2'd1,
        MUL_HI_UU = 2'd2,
        MUL_HI_SU = 2'd3
    } mul_kind_e;

    typedef enum logic [1:0] {
        EW_8  = 2'd0,
        EW_16 = 2'd1,
        EW_32 = 2'd2,
        EW_64 = 2'd3
    } elem_w_e;

    typedef struct packed {
        logic      legal;
        mul_kind_e kind;
        logic      use_scalar;
        logic      masked;
    } mul_ctl_t;

    function automatic logic kind_a_signed(mul_kind_e k);
        return (k == MUL_HI_SS) || (k == MUL_HI_SU);
    endfunction

    function automatic logic kind_b_signed(mul_kind_e k);
        return (k == MUL_HI_SS);
    endfunction

    function automatic logic kind_high(mul_kind_e k);
        return (k != MUL_LOW);
    endfunction

endpackage

// File: rtl/simd_mul_decode.sv
module simd_mul_decode
    import simd_mul_pkg::*;
(
    input  logic [31:0] instr,
    output mul_ctl_t    ctl
);
    logic [5:0] f6;
    logic [2:0] f3;
    logic       op_ok;
    logic       form_ok;
    logic       sel_ok;
    mul_kind_e  kind;
    logic       unused_fields;

    assign f6 = instr[31:26];
    assign f3 = instr[14:12];
    assign unused_fields = ^{instr[24:15], instr[11:7]};

    always_comb begin
        sel_ok = 1'b1;
        unique case (f6)
            SEL_LOW:   kind = MUL_LOW;
            SEL_HI_SS: kind = MUL_HI_SS;
            SEL_HI_UU: kind = MUL_HI_UU;
            SEL_HI_SU: kind = MUL_HI_SU;
            default: begin
                kind   = MUL_LOW;
                sel_ok = 1'b0;
            end
        endcase
    end

    assign op_ok   = (instr[6:0] == MAJOR_OP);
    assign form_ok = (f3 == FORM_VV) || (f3 == FORM_VX);

    assign ctl.legal      = op_ok && form_ok && sel_ok;
    assign ctl.kind       = kind;
    assign ctl.use_scalar = (f3 == FORM_VX);
    assign ctl.masked     = ~instr[25];

endmodule

// File: rtl/simd_mul_lane.sv
module simd_mul_lane #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         a_sgn,
    input  logic         b_sgn,
    input  logic         take_high,
    output logic [W-1:0] res
);
    localparam int unsigned PW = 2 * W + 2;

    logic signed [PW-1:0] ax;
    logic signed [PW-1:0] bx;
    logic signed [PW-1:0] prod;
    logic                 unused_top;

    assign ax   = {{(W + 2){a_sgn & a[W-1]}}, a};
    assign bx   = {{(W + 2){b_sgn & b[W-1]}}, b};
    assign prod = ax * bx;
    assign res  = take_high ? prod[2*W-1:W] : prod[W-1:0];
    assign unused_top = ^prod[PW-1:2*W];

endmodule

// File: rtl/simd_mul_bank.sv
module simd_mul_bank
    import simd_mul_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic [SLICE_W-1:0]   vs2,
    input  logic [SLICE_W-1:0]   vs1,
    input  logic [SLICE_W-1:0]   scalar,
    input  logic [MAX_LANES-1:0] mask,
    input  logic [SLICE_W-1:0]   old_dst,
    input  mul_ctl_t             ctl,
    output logic [SLICE_W-1:0]   res
);
    localparam int unsigned N = SLICE_W / W;

    logic a_sgn;
    logic b_sgn;
    logic hi;
    logic unused_bits;

    assign a_sgn = kind_a_signed(ctl.kind);
    assign b_sgn = kind_b_signed(ctl.kind);
    assign hi    = kind_high(ctl.kind);
    assign unused_bits = ^{scalar, mask, ctl.legal};

    for (genvar i = 0; i < N; i++) begin : g_lane
        logic [W-1:0] b_el;
        logic [W-1:0] prod_el;
        logic         active;

        assign b_el   = ctl.use_scalar ? scalar[W-1:0] : vs1[i*W +: W];
        assign active = ~ctl.masked | mask[i];

        simd_mul_lane #(.W(W)) u_lane (
            .a        (vs2[i*W +: W]),
            .b        (b_el),
            .a_sgn    (a_sgn),
            .b_sgn    (b_sgn),
            .take_high(hi),
            .res      (prod_el)
        );

        assign res[i*W +: W] = active ? prod_el : old_dst[i*W +: W];
    end

endmodule

// File: rtl/simd_mul_unit.sv
module simd_mul_unit
    import simd_mul_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic [31:0] instr,
    input  logic [1:0]  sew,
    input  logic [63:0] vs2,
    input  logic [63:0] vs1,
    input  logic [63:0] scalar,
    input  logic [7:0]  mask,
    input  logic [63:0] old_dst,
    output logic        out_valid,
    output logic [63:0] out_data,
    output logic        illegal
);
    localparam int unsigned NUM_W = 4;

    mul_ctl_t           ctl;
    logic [SLICE_W-1:0] bank_res [NUM_W];
    logic [SLICE_W-1:0] sel_res;
    logic               accept;

    simd_mul_decode u_dec (
        .instr(instr),
        .ctl  (ctl)
    );

    for (genvar g = 0; g < NUM_W; g++) begin : g_bank
        simd_mul_bank #(.W(8 << g)) u_bank (
            .vs2    (vs2),
            .vs1    (vs1),
            .scalar (scalar),
            .mask   (mask),
            .old_dst(old_dst),
            .ctl    (ctl),
            .res    (bank_res[g])
        );
    end

    always_comb begin
        unique case (elem_w_e'(sew))
            EW_8:    sel_res = bank_res[0];
            EW_16:   sel_res = bank_res[1];
            EW_32:   sel_res = bank_res[2];
            default: sel_res = bank_res[3];
        endcase
    end

    assign accept = in_valid && ctl.legal;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            illegal   <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= accept;
            illegal   <= in_valid && !ctl.legal;
            if (accept) begin
                out_data <= sel_res;
            end
        end
    end

    // R1: an unsupported word produces the illegal flag and no result
    a_r1_illegal_next: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !ctl.legal) |=> (illegal && !out_valid));

    // R2: a legal request produces a valid result one cycle later
    a_r2_valid_next: assert property (@(posedge clk) disable iff (rst)
        (in_valid && ctl.legal) |=> (out_valid && !illegal));

    // R2: no request, no flags
    a_r2_idle: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && !illegal));

    // R2: flags are mutually exclusive
    a_r2_exclusive: assert property (@(posedge clk) disable iff (rst)
        $onehot0({out_valid, illegal}));

    // R10: output data holds when nothing legal is accepted
    a_r10_hold: assert property (@(posedge clk) disable iff (rst)
        !(in_valid && ctl.legal) |=> $stable(out_data));

    // R9: masked-off element 0 keeps the old destination byte at any width
    a_r9_masked_keep: assert property (@(posedge clk) disable iff (rst)
        (in_valid && ctl.legal && ctl.masked && !mask[0])
        |=> (out_data[7:0] == $past(old_dst[7:0])));

endmodule

// File: tb/simd_mul_unit_tb.sv
module simd_mul_unit_tb;

    typedef struct packed {
        logic [1:0]  w;
        logic [5:0]  f6;
        logic [2:0]  f3;
        logic        vm;
        logic [63:0] a;
        logic [63:0] b;
        logic [63:0] s;
        logic [7:0]  m;
        logic [63:0] old;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t TBL [NV] = '{
        '{2'd0, 6'b100101, 3'b010, 1'b1, 64'h0102_0304_80FF_7F10, 64'h0506_0708_80FF_7F03, 64'h0, 8'h00, 64'h0},
        '{2'd0, 6'b100111, 3'b010, 1'b1, 64'h8080_FF7F_0181_C040, 64'h807F_FF7F_FF81_40C0, 64'h0, 8'h00, 64'h0},
        '{2'd0, 6'b100100, 3'b010, 1'b1, 64'h8080_FF7F_0181_C040, 64'h807F_FF7F_FF81_40C0, 64'h0, 8'h00, 64'h0},
        '{2'd0, 6'b100110, 3'b010, 1'b1, 64'h8080_FF7F_0181_C040, 64'h807F_FF7F_FF81_40C0, 64'h0, 8'h00, 64'h0},
        '{2'd1, 6'b100111, 3'b010, 1'b1, 64'h8000_7FFF_FFFF_1234, 64'h8000_8000_FFFF_ABCD, 64'h0, 8'h00, 64'h0},
        '{2'd1, 6'b100110, 3'b110, 1'b1, 64'h8000_7FFF_FFFF_1234, 64'h0, 64'hDEAD_BEEF_0000_F00D, 8'h00, 64'h0},
        '{2'd2, 6'b100100, 3'b010, 1'b1, 64'hFFFF_FFFF_8000_0001, 64'hFFFF_FFFF_7FFF_FFFF, 64'h0, 8'h00, 64'h0},
        '{2'd2, 6'b100111, 3'b110, 1'b1, 64'h8000_0000_1234_5678, 64'h0, 64'h1111_2222_8765_4321, 8'h00, 64'h0},
        '{2'd3, 6'b100111, 3'b010, 1'b1, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 64'h0, 8'h00, 64'h0},
        '{2'd3, 6'b100100, 3'b010, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFE, 64'h0, 8'h00, 64'h0},
        '{2'd3, 6'b100110, 3'b110, 1'b1, 64'hFEDC_BA98_7654_3210, 64'h0, 64'hF000_0000_0000_0003, 8'h00, 64'h0},
        '{2'd0, 6'b100101, 3'b010, 1'b0, 64'h1111_1111_1111_1111, 64'h0303_0303_0303_0303, 64'h0, 8'hA5, 64'hCCCC_CCCC_CCCC_CCCC}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] instr = '0;
    logic [1:0]  sew = '0;
    logic [63:0] vs2 = '0;
    logic [63:0] vs1 = '0;
    logic [63:0] scalar = '0;
    logic [7:0]  mask = '0;
    logic [63:0] old_dst = '0;
    logic        out_valid;
    logic [63:0] out_data;
    logic        illegal;

    int n_checks = 0;
    int n_fail   = 0;
    logic done = 1'b0;

    always #2 clk = ~clk;

    simd_mul_unit u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr), .sew(sew),
        .vs2(vs2), .vs1(vs1), .scalar(scalar), .mask(mask), .old_dst(old_dst),
        .out_valid(out_valid), .out_data(out_data), .illegal(illegal)
    );

    function automatic logic [31:0] mk(logic [5:0] f6, logic vm, logic [2:0] f3);
        return {f6, vm, 5'd2, 5'd1, f3, 5'd3, 7'b1010111};
    endfunction

    function automatic logic [63:0] model(vec_t v);
        int          w;
        int          n;
        logic        asg;
        logic        bsg;
        logic        hi;
        logic [63:0] m64;
        logic [63:0] r;
        w   = 8 << v.w;
        n   = 64 / w;
        asg = (v.f6 == 6'b100111) || (v.f6 == 6'b100110);
        bsg = (v.f6 == 6'b100111);
        hi  = (v.f6 != 6'b100101);
        m64 = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
        r   = '0;
        for (int e = 0; e < n; e++) begin
            logic [63:0]  av;
            logic [63:0]  bv;
            logic [129:0] ax;
            logic [129:0] bx;
            logic [129:0] p;
            logic [129:0] mk130;
            logic [63:0]  el;
            av = (v.a >> (e * w)) & m64;
            bv = (v.f3 == 3'b110) ? (v.s & m64) : ((v.b >> (e * w)) & m64);
            ax = {66'd0, av};
            bx = {66'd0, bv};
            if (asg && av[w-1]) ax = ax - (130'd1 << w);
            if (bsg && bv[w-1]) bx = bx - (130'd1 << w);
            p = ax * bx;
            mk130 = (130'd1 << w) - 130'd1;
            el = hi ? 64'((p >> w) & mk130) : 64'(p & mk130);
            if (!v.vm && !v.m[e]) el = (v.old >> (e * w)) & m64;
            r = r | (el << (e * w));
        end
        return r;
    endfunction

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(vec_t v, logic [31:0] iw);
        @(negedge clk);
        in_valid = 1'b1;
        instr    = iw;
        sew      = v.w;
        vs2      = v.a;
        vs1      = v.b;
        scalar   = v.s;
        mask     = v.m;
        old_dst  = v.old;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        vec_t v;
        logic [63:0] keep;
        repeat (3) @(negedge clk);
        // R10: reset state
        chk("R10 reset data", out_data, 64'h0);
        chk("R10 reset flags", {62'd0, out_valid, illegal}, 64'h0);
        rst = 1'b0;

        // R3 R4 R5 R6 R7 R8 R9: table walk
        for (int k = 0; k < NV; k++) begin
            drive(TBL[k], mk(TBL[k].f6, TBL[k].vm, TBL[k].f3));
            chk("R2 valid after table vector", {63'd0, out_valid}, 64'd1);
            chk("R3-7 table result", out_data, model(TBL[k]));
        end

        // R4 R5 R6 R3: hand values, 8-bit 0xFF x 0xFF
        v = '{2'd0, 6'b100111, 3'b010, 1'b1, '1, '1, 64'h0, 8'h00, 64'h0};
        drive(v, mk(6'b100111, 1'b1, 3'b010));
        chk("R4 signed high -1*-1", out_data, 64'h0);
        drive(v, mk(6'b100100, 1'b1, 3'b010));
        chk("R5 unsigned high 255*255", out_data, 64'hFEFE_FEFE_FEFE_FEFE);
        drive(v, mk(6'b100110, 1'b1, 3'b010));
        chk("R6 mixed high -1*255", out_data, 64'hFFFF_FFFF_FFFF_FFFF);
        drive(v, mk(6'b100101, 1'b1, 3'b010));
        chk("R3 low product", out_data, 64'h0101_0101_0101_0101);

        // R6: 64-bit mixed, negative times one and times max
        v = '{2'd3, 6'b100110, 3'b010, 1'b1, '1, 64'd1, 64'h0, 8'h00, 64'h0};
        drive(v, mk(6'b100110, 1'b1, 3'b010));
        chk("R6 64-bit -1*1 high", out_data, 64'hFFFF_FFFF_FFFF_FFFF);
        v.b = '1;
        drive(v, mk(6'b100110, 1'b1, 3'b010));
        chk("R6 64-bit -1*max high", out_data, 64'hFFFF_FFFF_FFFF_FFFF);
        v.a = 64'hFFFF_FFFF_FFFF_FFFE;
        v.b = 64'h8000_0000_0000_0000;
        drive(v, mk(6'b100110, 1'b1, 3'b010));
        chk("R6 64-bit -2*2^63 high", out_data, 64'hFFFF_FFFF_FFFF_FFFF);

        // R8: upper scalar bits ignored at 16 bits
        v = '{2'd1, 6'b100101, 3'b110, 1'b1, 64'h0001_0002_0003_0004, 64'hFFFF, 64'h0000_0000_0000_0005, 8'h00, 64'h0};
        drive(v, mk(6'b100101, 1'b1, 3'b110));
        chk("R8 scalar broadcast", out_data, 64'h0005_000A_000F_0014);
        v.s = 64'hABCD_1234_5678_0005;
        drive(v, mk(6'b100101, 1'b1, 3'b110));
        chk("R8 scalar upper bits ignored", out_data, 64'h0005_000A_000F_0014);

        // R9: vm=1 ignores mask; vm=0 keeps old lanes
        v = '{2'd2, 6'b100101, 3'b010, 1'b1, 64'h0000_0002_0000_0003, 64'h0000_0004_0000_0005, 64'h0, 8'h00, 64'h1111_1111_2222_2222};
        drive(v, mk(6'b100101, 1'b1, 3'b010));
        chk("R9 vm=1 mask ignored", out_data, 64'h0000_0008_0000_000F);
        v.m = 8'h02;
        drive(v, mk(6'b100101, 1'b0, 3'b010));
        chk("R9 vm=0 lane0 kept", out_data, 64'h0000_0008_2222_2222);

        // R1 R10: illegal words hold data
        keep = out_data;
        drive(v, {6'b100101, 1'b1, 5'd2, 5'd1, 3'b010, 5'd3, 7'b0110011});
        chk("R1 bad opcode flags", {62'd0, out_valid, illegal}, 64'd1);
        chk("R10 data held after bad opcode", out_data, keep);
        drive(v, mk(6'b100101, 1'b1, 3'b000));
        chk("R1 bad form flags", {62'd0, out_valid, illegal}, 64'd1);
        drive(v, mk(6'b000000, 1'b1, 3'b010));
        chk("R1 bad select flags", {62'd0, out_valid, illegal}, 64'd1);
        chk("R10 data held after bad select", out_data, keep);

        // R2 R10: idle cycle clears flags and holds data
        @(negedge clk);
        chk("R2 idle flags", {62'd0, out_valid, illegal}, 64'd0);
        chk("R10 idle hold", out_data, keep);

        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 20000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
        end
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule